// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block decides, every cycle, which pending interrupt a small processor should take next. Hardware sources are four active-low external request pins, an active-low power-fail pin, an active-low halt pin, an active-low reset request, and three internal requests: an interval timer, an Ethernet coprocessor and a console terminal. Software sources are fifteen pending bits, one per software level 1 to 15. These bits are set through a write port and shown as a summary register.

The block holds three registers: the current priority level, the software pending summary and a programmable Ethernet vector. From these and the live requests it computes a combinational result. The result says whether an interrupt is to be taken, its level, its vector offset, whether the external device must supply the vector, and whether it is a non-maskable halt with a halt code. When the processor pulses `ack` while a take is shown, the block updates its state. It loads the level register, and for a software interrupt it clears that level's pending bit.

Top module: `intr_level_arb`

## Requirements
- R1: After `rst_n` is deasserted, `ipl_o` reads 0x1F and `sisr_o` reads 0. With no request active, `int_take` is 0, and `int_level`, `int_vector`, `int_dev_vec`, `int_nmi` and `halt_code` are all 0.
- R2: An active reset request (low) gives `int_take`=1, `int_nmi`=1, `halt_code`=3 and level 0x1F. An active halt (low) gives the same outputs with `halt_code`=2. Reset wins over halt, and both are taken whatever the current level.
- R3: Acknowledging a non-maskable take loads the current level register with 0x1F on the next clock.
- R4: Power-fail requests level 0x1E with vector 0x0C. External pins 3, 2, 1 and 0 request levels 0x17, 0x16, 0x15 and 0x14. A winning pin sets `int_dev_vec`=1 and `int_vector`=0.
- R5: The interval timer requests level 0x16 with vector 0xC0 and wins over pin 2 when both are pending.
- R6: The Ethernet request takes level 0x15 and wins over pin 1. Its vector is the Ethernet vector register. A write to that register stores the write data with bits [1:0] forced to zero.
- R7: The console request takes level 0x14 with vector 0x2C0 and wins over pin 0.
- R8: A software request write of n (1 to 15) sets bit n of `sisr_o` on the next clock. A write of 0 changes nothing. The highest pending software level n is presented with vector 0x80+4n, and only when no hardware source is pending.
- R9: A maskable source is taken only when its level is strictly greater than `ipl_o`. The highest pending level wins.
- R10: Acknowledging a maskable take loads `ipl_o` with the taken level. For a software level it also clears that `sisr_o` bit, unless a software request write of the same level arrives in the same cycle; in that case the bit stays set.
- R11: A level write loads `ipl_o` with the write data on the next clock. If an acknowledged take happens in the same cycle, the acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| irq_n | input | 4 | External interrupt request pins, active low |
| pwrfail_n | input | 1 | Power-fail request, active low |
| halt_n | input | 1 | External halt request, active low |
| reset_req_n | input | 1 | Reset request (non-maskable), active low |
| tmr_req | input | 1 | Interval timer request |
| enet_req | input | 1 | Ethernet coprocessor request |
| con_req | input | 1 | Console terminal request |
| ack | input | 1 | Processor accepts the presented interrupt |
| ipl_we | input | 1 | Current level write enable |
| ipl_wdata | input | 5 | Current level write data |
| sirr_we | input | 1 | Software request write enable |
| sirr_wdata | input | 4 | Software request level |
| evec_we | input | 1 | Ethernet vector write enable |
| evec_wdata | input | 16 | Ethernet vector write data |
| int_take | output | 1 | An interrupt is to be taken |
| int_nmi | output | 1 | The take is a non-maskable halt |
| int_level | output | 5 | Level of the taken interrupt |
| int_vector | output | 16 | Vector offset of the taken interrupt |
| int_dev_vec | output | 1 | The vector must be fetched from the device |
| halt_code | output | 2 | Halt code for a non-maskable take |
| ipl_o | output | 5 | Current priority level register |
| sisr_o | output | 16 | Software pending summary register |

## Verification
The checker watches several rules on every cycle. It checks that a reset request always yields halt code 3 and that any maskable take lies strictly above the current level. It checks that an acknowledged halt raises the level to 0x1F and that an acknowledged software take clears its pending bit. It also checks that bit 0 of the summary stays zero and that every vector is longword aligned. The bench's scenarios are needed for the rest: the fixed tie order inside levels 0x14 to 0x16, the exact vector values, the Ethernet register's masking, write-of-zero having no effect, and the same-cycle collisions between acknowledge and register writes.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;
    localparam int LVL_W  = 5;
    localparam int VEC_W  = 16;
    localparam int SW_N   = 16;
    localparam int SWI_W  = $clog2(SW_N);
    localparam int HC_W   = 2;
    localparam int NPIN   = 4;

    localparam logic [LVL_W-1:0] LVL_NMI  = 5'h1F;
    localparam logic [LVL_W-1:0] LVL_PWR  = 5'h1E;
    localparam logic [LVL_W-1:0] LVL_P3   = 5'h17;
    localparam logic [LVL_W-1:0] LVL_P2   = 5'h16;
    localparam logic [LVL_W-1:0] LVL_P1   = 5'h15;
    localparam logic [LVL_W-1:0] LVL_P0   = 5'h14;

    localparam logic [VEC_W-1:0] VEC_PWR  = 16'h000C;
    localparam logic [VEC_W-1:0] VEC_TMR  = 16'h00C0;
    localparam logic [VEC_W-1:0] VEC_CON  = 16'h02C0;
    localparam logic [VEC_W-1:0] VEC_SWB  = 16'h0080;

    localparam logic [HC_W-1:0]  HC_RESET = 2'd3;
    localparam logic [HC_W-1:0]  HC_HALT  = 2'd2;

    typedef enum logic [3:0] {
        SRC_NONE, SRC_RESET, SRC_HALT, SRC_PWR, SRC_P3, SRC_TMR, SRC_P2,
        SRC_ENET, SRC_P1, SRC_CON, SRC_P0, SRC_SOFT
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [LVL_W-1:0] lvl;
        logic [VEC_W-1:0] vec;
        logic             dev;
        logic             nmi;
        logic [HC_W-1:0]  hcode;
    } pick_t;

    typedef struct packed {
        logic [LVL_W-1:0] ipl;
        logic [SW_N-1:0]  sisr;
        logic [VEC_W-1:0] evec;
    } arb_state_t;
endpackage

// File: rtl/intr_soft_enc.sv
module intr_soft_enc
    import intr_arb_pkg::*;
(
    input  logic [SW_N-1:0]  pend,
    output logic             found,
    output logic [SWI_W-1:0] idx
);
    logic [SWI_W-1:0] idx_w [SW_N];
    logic [SW_N-1:0]  any_w;

    // Ripple from level 1 upward; a higher set bit overrides lower ones.
    assign idx_w[0] = '0;
    assign any_w[0] = 1'b0;
    for (genvar g = 1; g < SW_N; g++) begin : g_scan
        assign any_w[g] = any_w[g-1] | pend[g];
        assign idx_w[g] = pend[g] ? SWI_W'(g) : idx_w[g-1];
    end

    assign found = any_w[SW_N-1];
    assign idx   = idx_w[SW_N-1];
endmodule

// File: rtl/intr_hw_pick.sv
module intr_hw_pick
    import intr_arb_pkg::*;
(
    input  logic             rst_act,
    input  logic             halt_act,
    input  logic             pwr_act,
    input  logic [NPIN-1:0]  pin_act,
    input  logic             tmr_act,
    input  logic             enet_act,
    input  logic             con_act,
    input  logic [VEC_W-1:0] evec,
    input  logic             sw_found,
    input  logic [SWI_W-1:0] sw_idx,
    output pick_t            pick
);
    always_comb begin
        pick = '{src: SRC_NONE, lvl: '0, vec: '0, dev: 1'b0, nmi: 1'b0, hcode: '0};
        if (rst_act) begin
            pick.src = SRC_RESET; pick.lvl = LVL_NMI; pick.nmi = 1'b1; pick.hcode = HC_RESET;
        end else if (halt_act) begin
            pick.src = SRC_HALT;  pick.lvl = LVL_NMI; pick.nmi = 1'b1; pick.hcode = HC_HALT;
        end else if (pwr_act) begin
            pick.src = SRC_PWR;   pick.lvl = LVL_PWR; pick.vec = VEC_PWR;
        end else if (pin_act[3]) begin
            pick.src = SRC_P3;    pick.lvl = LVL_P3;  pick.dev = 1'b1;
        end else if (tmr_act) begin
            pick.src = SRC_TMR;   pick.lvl = LVL_P2;  pick.vec = VEC_TMR;
        end else if (pin_act[2]) begin
            pick.src = SRC_P2;    pick.lvl = LVL_P2;  pick.dev = 1'b1;
        end else if (enet_act) begin
            pick.src = SRC_ENET;  pick.lvl = LVL_P1;  pick.vec = evec;
        end else if (pin_act[1]) begin
            pick.src = SRC_P1;    pick.lvl = LVL_P1;  pick.dev = 1'b1;
        end else if (con_act) begin
            pick.src = SRC_CON;   pick.lvl = LVL_P0;  pick.vec = VEC_CON;
        end else if (pin_act[0]) begin
            pick.src = SRC_P0;    pick.lvl = LVL_P0;  pick.dev = 1'b1;
        end else if (sw_found) begin
            pick.src = SRC_SOFT;
            pick.lvl = LVL_W'(sw_idx);
            pick.vec = VEC_SWB + (VEC_W'(sw_idx) << 2);
        end
    end
endmodule

// File: rtl/intr_level_arb.sv
module intr_level_arb
    import intr_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  irq_n,
    input  logic        pwrfail_n,
    input  logic        halt_n,
    input  logic        reset_req_n,
    input  logic        tmr_req,
    input  logic        enet_req,
    input  logic        con_req,
    input  logic        ack,
    input  logic        ipl_we,
    input  logic [4:0]  ipl_wdata,
    input  logic        sirr_we,
    input  logic [3:0]  sirr_wdata,
    input  logic        evec_we,
    input  logic [15:0] evec_wdata,
    output logic        int_take,
    output logic        int_nmi,
    output logic [4:0]  int_level,
    output logic [15:0] int_vector,
    output logic        int_dev_vec,
    output logic [1:0]  halt_code,
    output logic [4:0]  ipl_o,
    output logic [15:0] sisr_o
);
    localparam arb_state_t ST_RST = '{ipl: LVL_NMI, sisr: '0, evec: '0};

    arb_state_t       st_q, st_d;
    pick_t            pick;
    logic             sw_found;
    logic [SWI_W-1:0] sw_idx;
    logic             take;
    logic             accept;

    intr_soft_enc u_soft (
        .pend  (st_q.sisr),
        .found (sw_found),
        .idx   (sw_idx)
    );

    intr_hw_pick u_pick (
        .rst_act  (~reset_req_n),
        .halt_act (~halt_n),
        .pwr_act  (~pwrfail_n),
        .pin_act  (~irq_n),
        .tmr_act  (tmr_req),
        .enet_act (enet_req),
        .con_act  (con_req),
        .evec     (st_q.evec),
        .sw_found (sw_found),
        .sw_idx   (sw_idx),
        .pick     (pick)
    );

    // The pick is the highest pending source, so one compare masks it.
    assign take   = pick.nmi | ((pick.src != SRC_NONE) && (pick.lvl > st_q.ipl));
    assign accept = take & ack;

    always_comb begin
        st_d = st_q;
        if (ipl_we)
            st_d.ipl = ipl_wdata;
        if (accept)
            st_d.ipl = pick.lvl;
        if (accept && pick.src == SRC_SOFT)
            st_d.sisr[sw_idx] = 1'b0;
        if (sirr_we && sirr_wdata != '0)
            st_d.sisr[sirr_wdata] = 1'b1;
        st_d.sisr[0] = 1'b0;
        if (evec_we)
            st_d.evec = {evec_wdata[VEC_W-1:2], 2'b00};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign int_take    = take;
    assign int_nmi     = take & pick.nmi;
    assign int_level   = take ? pick.lvl   : '0;
    assign int_vector  = take ? pick.vec   : '0;
    assign int_dev_vec = take & pick.dev;
    assign halt_code   = take ? pick.hcode : '0;
    assign ipl_o       = st_q.ipl;
    assign sisr_o      = st_q.sisr;
endmodule

// File: rtl/intr_level_arb_chk.sv
module intr_level_arb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reset_req_n,
    input logic        ack,
    input logic        sirr_we,
    input logic [3:0]  sirr_wdata,
    input logic        int_take,
    input logic        int_nmi,
    input logic [4:0]  int_level,
    input logic [15:0] int_vector,
    input logic        int_dev_vec,
    input logic [1:0]  halt_code,
    input logic [4:0]  ipl_o,
    input logic [15:0] sisr_o
);
    p_reset_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reset_req_n |-> (int_take && int_nmi && halt_code == 2'd3));

    p_nmi_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_nmi) |=> (ipl_o == 5'h1F));

    p_mask_above_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_take && !int_nmi) |-> (int_level > ipl_o));

    p_accept_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_take) |=> (ipl_o == $past(int_level)));

    p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_take && !int_nmi && int_level < 5'd16)
        |=> (!sisr_o[$past(int_level[3:0])]
             || $past(sirr_we && sirr_wdata == int_level[3:0])));

    p_bit0_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sisr_o[0]);

    p_vec_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_vector[1:0] == 2'b00);

    p_devvec_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int_dev_vec |-> (int_take && int_vector == 16'h0 && !int_nmi));
endmodule

bind intr_level_arb intr_level_arb_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_req_n (reset_req_n),
    .ack         (ack),
    .sirr_we     (sirr_we),
    .sirr_wdata  (sirr_wdata),
    .int_take    (int_take),
    .int_nmi     (int_nmi),
    .int_level   (int_level),
    .int_vector  (int_vector),
    .int_dev_vec (int_dev_vec),
    .halt_code   (halt_code),
    .ipl_o       (ipl_o),
    .sisr_o      (sisr_o)
);

// File: tb/intr_level_arb_tb.sv
`timescale 1ns/1ps
module intr_level_arb_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_n = 4'hF;
    logic        pwrfail_n = 1'b1, halt_n = 1'b1, reset_req_n = 1'b1;
    logic        tmr_req = 1'b0, enet_req = 1'b0, con_req = 1'b0, ack = 1'b0;
    logic        ipl_we = 1'b0, sirr_we = 1'b0, evec_we = 1'b0;
    logic [4:0]  ipl_wdata = '0;
    logic [3:0]  sirr_wdata = '0;
    logic [15:0] evec_wdata = '0;
    logic        int_take, int_nmi, int_dev_vec;
    logic [4:0]  int_level, ipl_o;
    logic [15:0] int_vector, sisr_o;
    logic [1:0]  halt_code;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // model state
    logic [4:0]  m_ipl;
    logic [15:0] m_sisr, m_evec;
    // expected outputs
    logic        e_take, e_nmi, e_dev;
    logic [4:0]  e_lvl;
    logic [15:0] e_vec;
    logic [1:0]  e_hc;
    string       e_tag;

    always #2.5 clk = ~clk;

    intr_level_arb u_dut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected pick from the requirements, source by source.
    task automatic model_pick();
        logic       cand;
        logic [4:0] l;
        cand = 1'b1; e_nmi = 1'b0; e_dev = 1'b0; e_vec = '0; e_hc = '0; l = '0;
        if (!reset_req_n)     begin e_nmi = 1; e_hc = 3; l = 5'h1F; e_tag = "R2"; end
        else if (!halt_n)     begin e_nmi = 1; e_hc = 2; l = 5'h1F; e_tag = "R2"; end
        else if (!pwrfail_n)  begin l = 5'h1E; e_vec = 16'h0C; e_tag = "R4"; end
        else if (!irq_n[3])   begin l = 5'h17; e_dev = 1; e_tag = "R4"; end
        else if (tmr_req)     begin l = 5'h16; e_vec = 16'hC0; e_tag = "R5"; end
        else if (!irq_n[2])   begin l = 5'h16; e_dev = 1; e_tag = "R5"; end
        else if (enet_req)    begin l = 5'h15; e_vec = m_evec; e_tag = "R6"; end
        else if (!irq_n[1])   begin l = 5'h15; e_dev = 1; e_tag = "R6"; end
        else if (con_req)     begin l = 5'h14; e_vec = 16'h2C0; e_tag = "R7"; end
        else if (!irq_n[0])   begin l = 5'h14; e_dev = 1; e_tag = "R7"; end
        else begin
            cand = 1'b0; e_tag = "R9";
            for (int i = 15; i >= 1; i--)
                if (m_sisr[i]) begin
                    cand = 1'b1; l = 5'(i); e_vec = 16'h80 + 16'(4*i); e_tag = "R8";
                    break;
                end
        end
        e_take = e_nmi || (cand && l > m_ipl);
        if (!e_take) begin
            if (cand) e_tag = "R9";
            e_nmi = 0; e_dev = 0; e_vec = '0; e_hc = '0; l = '0;
        end
        e_lvl = l;
    endtask

    // One cycle: check the outputs before the edge, then advance the model.
    task automatic step();
        @(negedge clk);
        model_pick();
        chk({e_tag, " take"},  32'(int_take),    32'(e_take));
        chk({e_tag, " nmi"},   32'(int_nmi),     32'(e_nmi));
        chk({e_tag, " level"}, 32'(int_level),   32'(e_lvl));
        chk({e_tag, " vec"},   32'(int_vector),  32'(e_vec));
        chk({e_tag, " dev"},   32'(int_dev_vec), 32'(e_dev));
        chk({e_tag, " hcode"}, 32'(halt_code),   32'(e_hc));
        chk("R11 ipl",  32'(ipl_o),  32'(m_ipl));
        chk("R10 sisr", 32'(sisr_o), 32'(m_sisr));
        if (ipl_we) m_ipl = ipl_wdata;
        if (ack && e_take) begin
            m_ipl = e_lvl;
            if (!e_nmi && e_lvl < 16) m_sisr[e_lvl[3:0]] = 1'b0;
        end
        if (sirr_we && sirr_wdata != 0) m_sisr[sirr_wdata] = 1'b1;
        if (evec_we) m_evec = {evec_wdata[15:2], 2'b00};
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        irq_n = 4'hF; pwrfail_n = 1; halt_n = 1; reset_req_n = 1;
        tmr_req = 0; enet_req = 0; con_req = 0; ack = 0;
        ipl_we = 0; sirr_we = 0; evec_we = 0;
    endtask

    task automatic set_ipl(logic [4:0] v);
        idle(); ipl_we = 1; ipl_wdata = v; step(); idle();
    endtask

    initial begin
        m_ipl = 5'h1F; m_sisr = '0; m_evec = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values and quiet outputs
        @(negedge clk);
        chk("R1 ipl",  32'(ipl_o), 32'h1F);
        chk("R1 sisr", 32'(sisr_o), 32'h0);
        chk("R1 take", 32'(int_take), 32'h0);
        chk("R1 vec",  32'(int_vector), 32'h0);
        @(posedge clk); #1;

        // R9: pin 0 masked at ipl 0x1F, then lowered
        idle(); irq_n[0] = 0; step();
        set_ipl(5'h14); irq_n[0] = 0; step();
        set_ipl(5'h13); irq_n[0] = 0; step();
        // R7 console ahead of pin 0
        con_req = 1; step();
        set_ipl(5'h00);
        // R8: write zero ignored, levels 5 and 15
        sirr_we = 1; sirr_wdata = 0; step(); idle();
        @(negedge clk); chk("R8 zero write", 32'(sisr_o), 32'h0); @(posedge clk); #1;
        sirr_we = 1; sirr_wdata = 5; step(); idle();
        sirr_we = 1; sirr_wdata = 15; step(); idle();
        step();
        // R8 below hardware: pin 0 pre-empts software
        irq_n[0] = 0; step(); idle();
        // R10: accept level 15 while writing level 15 again -> stays set
        ack = 1; sirr_we = 1; sirr_wdata = 15; step(); idle();
        @(negedge clk);
        chk("R10 ipl load", 32'(ipl_o), 32'h0F);
        chk("R10 same-cycle set wins", 32'(sisr_o[15]), 32'h1);
        @(posedge clk); #1;
        set_ipl(5'h0E);
        ack = 1; step(); idle();
        @(negedge clk); chk("R10 soft clear", 32'(sisr_o[15]), 32'h0); @(posedge clk); #1;
        // R11: ack wins over ipl write
        set_ipl(5'h00);
        ack = 1; ipl_we = 1; ipl_wdata = 5'h03; step(); idle();
        @(negedge clk); chk("R11 ack over write", 32'(ipl_o), 32'h05); @(posedge clk); #1;
        // R6: ethernet vector masked to longword, beats pin 1
        set_ipl(5'h00);
        evec_we = 1; evec_wdata = 16'h1237; step(); idle();
        enet_req = 1; irq_n[1] = 0; step();
        @(negedge clk); chk("R6 evec mask", 32'(int_vector), 32'h1234); @(posedge clk); #1;
        // R5 timer over pin 2, R4 pin 3 and power-fail
        idle(); tmr_req = 1; irq_n[2] = 0; step();
        irq_n[3] = 0; step();
        pwrfail_n = 0; step();
        // R2: halt, then reset over halt, at ipl 0x1F
        set_ipl(5'h1F);
        halt_n = 0; step();
        reset_req_n = 0; step();
        // R3: accepting an NMI sets ipl to 0x1F
        set_ipl(5'h02);
        halt_n = 0; ack = 1; step(); idle();
        @(negedge clk); chk("R3 nmi raise", 32'(ipl_o), 32'h1F); @(posedge clk); #1;

        // random phase
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < 4000; k++) begin
            irq_n       = ~{($urandom%8)==0, ($urandom%8)==0, ($urandom%8)==0, ($urandom%8)==0};
            pwrfail_n   = ($urandom % 24) != 0;
            halt_n      = ($urandom % 40) != 0;
            reset_req_n = ($urandom % 64) != 0;
            tmr_req     = ($urandom % 8) == 0;
            enet_req    = ($urandom % 8) == 0;
            con_req     = ($urandom % 8) == 0;
            ack         = ($urandom % 2) == 0;
            ipl_we      = ($urandom % 6) == 0;
            ipl_wdata   = 5'($urandom);
            sirr_we     = ($urandom % 3) == 0;
            sirr_wdata  = 4'($urandom);
            evec_we     = ($urandom % 16) == 0;
            evec_wdata  = 16'($urandom);
            step();
        end
        idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule